// File: doc/BRIEF.md
# Streaming FIFO-Port Add Engine

This block sits between a compute step and two external FIFOs. On the input side it watches an active-low "input FIFO is empty" status (High means a word is available) and pulls words with a read acknowledge. On the output side it watches an active-low "output FIFO is full" status (High means space is free) and pushes results with a write strobe. Both sides stall on their own: an empty input FIFO stops the reads, and a full output FIFO stops the writes while the pending result stays on the output data port.

A transaction begins with a one-cycle start pulse while the engine is idle. The engine then consumes exactly `COUNT` words in order, adds the constant `ADDEND` to each (modulo 2^`DATA_W`), and writes the results in the same order. The read and write sides form a two-stage pipeline joined by a one-word holding register, so one word per cycle flows when neither FIFO stalls. A last-write flag accompanies the final write, and a one-cycle done pulse follows it.

Top module: `stream_add_engine`

## Requirements
- R1: While reset is asserted (rst_n Low) and in the first cycle after it, `in_read`, `out_write`, `out_last` and `done` are Low and `out_data` is zero.
- R2: While idle (no start accepted, or after done), the engine never asserts `in_read` or `out_write`, whatever `in_empty_n` and `out_full_n` show.
- R3: `in_read` is High only in a cycle where `in_empty_n` is High; in that cycle the word on `in_data` is consumed.
- R4: When the engine wants a word and `in_empty_n` is Low, it stalls with `in_read` Low until `in_empty_n` returns High.
- R5: Each written word equals the corresponding read word plus `ADDEND`, truncated to `DATA_W` bits, and results leave in the order words arrived.
- R6: `out_write` is High only when `out_full_n` is High; while a result is pending and `out_full_n` is Low, `out_data` holds that result unchanged.
- R7: A transaction performs exactly `COUNT` reads and `COUNT` writes; no read is made beyond the `COUNT`-th word.
- R8: `out_last` is High in the cycle of the `COUNT`-th write and in no other cycle.
- R9: `done` is High for exactly one cycle, the cycle right after the write that carries `out_last`.
- R10: With both FIFOs always ready, reads occur in the `COUNT` consecutive cycles after the start cycle, writes lag reads by one cycle, and `done` rises `COUNT`+2 cycles after the start cycle.
- R11: A start pulse that arrives while a transaction is running has no effect: the running transaction still makes exactly `COUNT` reads and writes and one done pulse, and no further reads follow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active Low |
| start | input | 1 | One-cycle pulse that begins a transaction when idle |
| in_empty_n | input | 1 | Input FIFO has a word available (High) |
| in_data | input | DATA_W | Word at the head of the input FIFO |
| in_read | output | 1 | Read acknowledge: head word consumed this cycle |
| out_full_n | input | 1 | Output FIFO has space (High) |
| out_data | output | DATA_W | Result word, presented also while stalled |
| out_write | output | 1 | Write strobe: result accepted this cycle |
| out_last | output | 1 | Marks the final write of the transaction |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The add path is driven with four status patterns: both FIFOs always ready, which measures the one-word-per-cycle rate and the exact done latency; a periodic empty input, which separates read stalls from write behaviour; periodic full output, which fills the holding register and shows whether the pending result is held and the read side backs off; and pseudo-random stalls on both sides at once, which exercises simultaneous read-into-holding and write-out. A wrap-around word near the top of the data range tells a correct modulo add apart from a wider one, and a stray start during a run plus an idle window with data present show that the engine ignores what it must ignore.

// File: rtl/sae_pkg.sv
// Package: shared types for the streaming add engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sae_pkg;

    // Transaction phase of the engine.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    // Modulo add of a word and a constant of the same width.
    function automatic logic [63:0] wrap_add64(input logic [63:0] a, input logic [63:0] b);
        return a + b;
    endfunction

endpackage

// File: rtl/sae_ctrl.sv
// Module: sae_ctrl
// Tracks whether a transaction runs. Accepts start only when idle, raises a
// one-cycle clear for the counters at that point, and ends the run on the
// final write, pulsing done in the following cycle.
// Assumes start is a pulse; a start while running is ignored.
module sae_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic final_fire,
    output logic busy,
    output logic clear,
    output logic done
);
    import sae_pkg::*;

    phase_t phase_q;

    // Start is accepted only from the idle phase.
    assign clear = (phase_q == PH_IDLE) && start;
    assign busy  = (phase_q == PH_RUN);

    // Phase register: idle to run on start, run to idle on final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (clear) begin
            phase_q <= PH_RUN;
        end else if (busy && final_fire) begin
            phase_q <= PH_IDLE;
        end
    end

    // Done pulse register: one cycle after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= busy && final_fire;
        end
    end

endmodule

// File: rtl/sae_read_stage.sv
// Module: sae_read_stage
// Pulls words from the input FIFO while the run is active, fewer than COUNT
// words have been taken, the FIFO shows data and the holding stage can take
// a word. Forms the sum of the incoming word and the constant.
// Assumes in_data is valid whenever in_empty_n is High.
module sae_read_stage #(
    parameter int DATA_W = 32,
    parameter int COUNT  = 50,
    parameter int ADDEND = 5,
    parameter int CNT_W  = $clog2(COUNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              clear,
    input  logic              in_empty_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              slot_free,
    output logic              in_read,
    output logic [DATA_W-1:0] sum
);
    localparam logic [CNT_W-1:0]  RD_LIMIT = CNT_W'(COUNT);
    localparam logic [DATA_W-1:0] ADD_V    = DATA_W'(ADDEND);

    logic [CNT_W-1:0] rd_cnt;
    logic             want_word;

    // A word is wanted while the run has reads left.
    assign want_word = busy && (rd_cnt != RD_LIMIT);
    // Consume only when data is present and the holding stage has room.
    assign in_read   = want_word && in_empty_n && slot_free;
    // Modulo add of the constant.
    assign sum       = in_data + ADD_V;

    // Read counter: cleared at start, advanced on each consumed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
        end else if (clear) begin
            rd_cnt <= '0;
        end else if (in_read) begin
            rd_cnt <= rd_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sae_write_stage.sv
// Module: sae_write_stage
// One-word holding register feeding the output FIFO. The held result is
// always driven on out_data; it is written when out_full_n is High. A new
// word may be loaded in the same cycle the held one leaves.
// Assumes load is only raised when slot_free is High.
module sae_write_stage #(
    parameter int DATA_W = 32,
    parameter int COUNT  = 50,
    parameter int CNT_W  = $clog2(COUNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] sum,
    input  logic              out_full_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_write,
    output logic              out_last,
    output logic              hold_valid,
    output logic              slot_free,
    output logic              final_fire
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(COUNT - 1);

    logic [DATA_W-1:0] hold_data;
    logic [CNT_W-1:0]  wr_cnt;

    // Write only when a result is held and the output FIFO has room.
    assign out_write  = hold_valid && out_full_n;
    // Room exists if empty now or emptying this cycle.
    assign slot_free  = !hold_valid || out_full_n;
    assign out_data   = hold_data;
    // Final write of the transaction.
    assign final_fire = out_write && (wr_cnt == LAST_IDX);
    assign out_last   = final_fire;

    // Holding register valid flag: set on load, cleared when written out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
        end else if (load) begin
            hold_valid <= 1'b1;
        end else if (out_write) begin
            hold_valid <= 1'b0;
        end
    end

    // Holding register data: captures the sum on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
        end else if (load) begin
            hold_data <= sum;
        end
    end

    // Write counter: cleared at start, advanced on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (clear) begin
            wr_cnt <= '0;
        end else if (out_write) begin
            wr_cnt <= wr_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/stream_add_engine.sv
// Module: stream_add_engine (top)
// Reads COUNT words from an input FIFO port, adds ADDEND to each and writes
// the results to an output FIFO port, stalling on either side. Start begins
// a run, out_last marks the final write, done pulses one cycle later.
// Assumes COUNT >= 1 and external FIFOs with show-ahead data.
module stream_add_engine #(
    parameter int DATA_W = 32,
    parameter int COUNT  = 50,
    parameter int ADDEND = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_empty_n,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_read,
    input  logic              out_full_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_write,
    output logic              out_last,
    output logic              done
);
    localparam int CNT_W = $clog2(COUNT + 1);

    logic              busy;
    logic              clear;
    logic              slot_free;
    logic              hold_valid;
    logic              final_fire;
    logic [DATA_W-1:0] sum;

    sae_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .final_fire (final_fire),
        .busy       (busy),
        .clear      (clear),
        .done       (done)
    );

    sae_read_stage #(
        .DATA_W (DATA_W),
        .COUNT  (COUNT),
        .ADDEND (ADDEND),
        .CNT_W  (CNT_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .clear      (clear),
        .in_empty_n (in_empty_n),
        .in_data    (in_data),
        .slot_free  (slot_free),
        .in_read    (in_read),
        .sum        (sum)
    );

    sae_write_stage #(
        .DATA_W (DATA_W),
        .COUNT  (COUNT),
        .CNT_W  (CNT_W)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .load       (in_read),
        .sum        (sum),
        .out_full_n (out_full_n),
        .out_data   (out_data),
        .out_write  (out_write),
        .out_last   (out_last),
        .hold_valid (hold_valid),
        .slot_free  (slot_free),
        .final_fire (final_fire)
    );

endmodule

// File: rtl/sae_checker.sv
// Module: sae_checker
// Protocol checks for stream_add_engine, attached by bind.
// Assumes the engine's busy and hold_valid nets are visible at its top.
module sae_checker #(
    parameter int DATA_W = 32,
    parameter int COUNT  = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_empty_n,
    input logic              in_read,
    input logic              out_full_n,
    input logic [DATA_W-1:0] out_data,
    input logic              out_write,
    input logic              out_last,
    input logic              done,
    input logic              busy,
    input logic              hold_valid
);
    localparam int CW = $clog2(COUNT + 2);

    logic [CW-1:0] wr_seen;

    // Writes seen in the current run, restarted after done.
    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            wr_seen <= '0;
        end else if (out_write) begin
            wr_seen <= wr_seen + CW'(1);
        end
    end

    AST_READ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) in_read |-> in_empty_n); // R3
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !in_read); // R2
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !out_write); // R2
    AST_WRITE_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n) out_write |-> out_full_n); // R6
    AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (hold_valid && !out_full_n) |=> (hold_valid && $stable(out_data))); // R6
    AST_LAST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_write); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) out_last |=> done); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_WRITES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) wr_seen <= CW'(COUNT)); // R7

endmodule

bind stream_add_engine sae_checker #(
    .DATA_W (DATA_W),
    .COUNT  (COUNT)
) u_sae_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_empty_n (in_empty_n),
    .in_read    (in_read),
    .out_full_n (out_full_n),
    .out_data   (out_data),
    .out_write  (out_write),
    .out_last   (out_last),
    .done       (done),
    .busy       (busy),
    .hold_valid (hold_valid)
);

// File: tb/stream_add_engine_test.sv
// Directed bench for stream_add_engine: one task per scenario, each checking
// its own results against a model derived from the requirements.
module stream_add_engine_test;

    localparam int DATA_W = 32;
    localparam int COUNT  = 50;
    localparam int ADDEND = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              in_empty_n = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_read;
    logic              out_full_n = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              out_write;
    logic              out_last;
    logic              done;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] src [COUNT];
    logic [15:0]       lfsr = 16'hACE1;

    stream_add_engine #(
        .DATA_W (DATA_W),
        .COUNT  (COUNT),
        .ADDEND (ADDEND)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_empty_n (in_empty_n),
        .in_data    (in_data),
        .in_read    (in_read),
        .out_full_n (out_full_n),
        .out_data   (out_data),
        .out_write  (out_write),
        .out_last   (out_last),
        .done       (done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic report_end();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            report_end();
        end
    end

    task automatic fill_src(input logic [DATA_W-1:0] seed, input bit wrap_first);
        for (int i = 0; i < COUNT; i++) begin
            src[i] = seed + DATA_W'(i) * 32'h01030107;
        end
        if (wrap_first) begin
            src[0] = 32'hFFFF_FFFE;
            src[1] = 32'hFFFF_FFFB;
        end
    endtask

    function automatic bit gate_empty(input int mode, input int c, input logic [15:0] r);
        case (mode)
            1:       return (c % 3) != 1;
            3:       return r[0] | r[3];
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit gate_full(input int mode, input int c, input logic [15:0] r);
        case (mode)
            2:       return (c % 4) >= 2;
            3:       return r[5] | r[9];
            default: return 1'b1;
        endcase
    endfunction

    // R1: outputs quiet during and right after reset.
    task automatic test_reset();
        rst_n = 1'b0;
        in_empty_n = 1'b1;
        out_full_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!in_read && !out_write && !out_last && !done, "R1 ctrl in reset",
              {in_read, out_write, out_last, done}, 0);
        check(out_data == '0, "R1 data in reset", out_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!in_read && !out_write && !done, "R1 after release",
              {in_read, out_write, done}, 0);
        check(out_data == '0, "R1 data after release", out_data, 0);
    endtask

    // R2: idle engine ignores ready FIFOs.
    task automatic test_idle_quiet(input int cycles);
        int bad = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_empty_n = 1'b1;
            out_full_n = 1'b1;
            in_data = 32'h1234_0000 + DATA_W'(c);
            #1;
            if (in_read || out_write || done) bad++;
        end
        check(bad == 0, "R2 idle ignores ready FIFOs", bad, 0);
    endtask

    // One transaction with a stall pattern; restart_at >= 0 pulses start mid-run.
    task automatic run_txn(input int mode, input int restart_at, input string tag);
        bit m_busy = 1'b0;
        bit pend = 1'b0;
        int reads = 0;
        int writes = 0;
        int last_c = -100;
        int done_c = -1;
        int dones = 0;
        int stall_bad = 0;
        int c = 0;
        logic [DATA_W-1:0] prev_data = '0;
        bit prev_stall = 1'b0;
        while (c < 3000) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            start      = (c == 0) || (c == restart_at);
            in_empty_n = (reads < COUNT) ? gate_empty(mode, c, lfsr) : (mode == 3 ? lfsr[1] : 1'b1);
            in_data    = (reads < COUNT) ? src[reads] : 32'hDEAD_BEEF;
            out_full_n = gate_full(mode, c, lfsr);
            #1;
            begin
                bit exp_read = m_busy && (reads < COUNT) && in_empty_n && (!pend || out_full_n);
                bit exp_write = pend && out_full_n;
                bit exp_done = (c == last_c + 1);
                check(in_read == exp_read, {"R3 R4 R7 read ack ", tag}, in_read, exp_read);
                check(out_write == exp_write, {"R6 write strobe ", tag}, out_write, exp_write);
                check(done == exp_done, {"R9 done timing ", tag}, done, exp_done);
                if (prev_stall && pend && out_data != prev_data) stall_bad++;
                if (done) begin
                    dones++;
                    done_c = c;
                end
                if (exp_write) begin
                    check(out_data == src[writes] + DATA_W'(ADDEND), {"R5 result ", tag},
                          out_data, src[writes] + DATA_W'(ADDEND));
                    check(out_last == (writes == COUNT - 1), {"R8 last flag ", tag},
                          out_last, writes == COUNT - 1);
                    writes++;
                    if (writes == COUNT) begin
                        last_c = c;
                        m_busy = 1'b0;
                    end
                end else begin
                    check(!out_last, {"R8 last without write ", tag}, out_last, 0);
                end
                prev_stall = pend && !out_full_n;
                prev_data  = out_data;
                if (exp_read) begin
                    reads++;
                    pend = 1'b1;
                end else if (exp_write) begin
                    pend = 1'b0;
                end
                if (start && !m_busy && writes == 0) m_busy = 1'b1;
            end
            c++;
            if (last_c >= 0 && c > last_c + 6) break;
        end
        start = 1'b0;
        check(stall_bad == 0, {"R6 data held while stalled ", tag}, stall_bad, 0);
        check(writes == COUNT, {"R7 write count ", tag}, writes, COUNT);
        check(reads == COUNT, {"R7 read count ", tag}, reads, COUNT);
        check(dones == 1, {"R9 single done ", tag}, dones, 1);
        if (mode == 0) begin
            check(done_c == COUNT + 2, {"R10 done latency ", tag}, done_c, COUNT + 2);
        end
    endtask

    initial begin
        test_reset();
        test_idle_quiet(10);

        fill_src(32'h0000_0100, 1'b1);
        run_txn(0, -1, "free-run");       // R10 throughput, R5 wrap
        test_idle_quiet(8);

        fill_src(32'h0A00_0000, 1'b0);
        run_txn(1, -1, "empty-gaps");     // R4

        fill_src(32'h7FFF_FFF0, 1'b0);
        run_txn(2, -1, "full-stalls");    // R6

        fill_src(32'h1357_9BDF, 1'b1);
        run_txn(3, -1, "random-both");

        fill_src(32'h0000_0042, 1'b0);
        run_txn(0, 17, "restart-busy");   // R11 start while running
        test_idle_quiet(12);              // R11 no reads after the run

        report_end();
    end

endmodule